// File: doc/BRIEF.md
# Auto-Negotiation Control Sequencer

This block decides how one port's PHY brings its link up. It handles three cases. Auto-negotiation is driven by received fast link pulse bursts. Forced operation takes the speed and duplex straight from the control bits. Parallel detection handles a link partner that only sends 100M idle symbols or 10M normal link pulses. Detection events arrive as single-cycle pulses from the analog and decode logic. The block presents the resolved speed, duplex and link state together with a transmit/receive enable.

A management restart, or a pulse on `restart_req`, drops all traffic. It then holds the link down for a long break period before negotiation begins again, so the partner also sees the link vanish. A loss of signal on an established link goes straight back to ability detection, with no break period.

The block maintains two pieces of status. The first is a partner-ability word. The second is a pair of expansion flags: one marks that the partner can negotiate, and one marks a parallel detection fault that clears when software reads it.

Top module: `autoneg_sequencer`

## Requirements
- R1: After reset the link is down. Transmit/receive is disabled, both expansion flags are 0 and the partner-ability word is 0.
- R2: With `an_enable` low, the block is in forced mode. Two cycles after `an_enable` falls, `speed_100` equals `ctl_speed100` and `full_duplex` equals `ctl_full`. In forced mode, `link_up` and `txrx_en` follow `link_ok`.
- R3: While `an_enable` is high, changes on `ctl_speed100` and `ctl_full` have no effect on `speed_100` or `full_duplex`.
- R4: An FLP burst pulse during ability detection has three effects. It loads `lp_ability` from `lp_word` and sets `exp_lp_an_able`. Two cycles after the pulse, it brings the link up in the highest common mode of `adv_ability & lp_word`. Bit encoding: [3]=100 full, [2]=100 half, [1]=10 full, [0]=10 half. The priority runs 100 full, 100 half, 10 full, 10 half.
- R5: If `adv_ability` and the partner word share no mode, the link stays down and detection resumes.
- R6: Parallel detection works as follows. A 100M idle or 10M link pulse during ability detection opens a window of DETECT_CYC cycles. If only one kind of pulse is seen in that window, the link comes up in half duplex at that speed. `exp_lp_an_able` is cleared, and `lp_ability` becomes 4'b0100 (100M) or 4'b0001 (10M).
- R7: If both the 100M and the 10M kinds of pulse are seen inside one window, `exp_pd_fault` is set. The link stays down and detection resumes.
- R8: A pulse on `exp_read` clears `exp_pd_fault`.
- R9: A restart pulse with `an_enable` high has three effects on the next edge. It gives a one-cycle `restart_ack`, drops `link_up` and `txrx_en`, and starts a break period. The break ends exactly BREAK_CYC cycles after it was entered. FLP pulses during the break are ignored.
- R10: When `link_ok` falls while the link is up, the link drops on the next edge. An FLP pulse in the very next cycle is accepted, with no break period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| an_enable | input | 1 | Auto-negotiation enable control bit |
| restart_req | input | 1 | Restart control bit; cleared by software on `restart_ack` |
| ctl_speed100 | input | 1 | Forced speed, 1 = 100M |
| ctl_full | input | 1 | Forced duplex, 1 = full |
| link_ok | input | 1 | Receive signal present |
| flp_det | input | 1 | FLP burst received pulse |
| idle100_det | input | 1 | 100M idle symbol detect pulse |
| nlp10_det | input | 1 | 10M normal link pulse detect |
| adv_ability | input | 4 | Local advertised modes |
| lp_word | input | 4 | Partner modes decoded from the FLP burst |
| exp_read | input | 1 | Expansion status read strobe |
| link_up | output | 1 | Link established |
| txrx_en | output | 1 | Transmit/receive permitted |
| speed_100 | output | 1 | Resolved speed, 1 = 100M |
| full_duplex | output | 1 | Resolved duplex, 1 = full |
| lp_ability | output | 4 | Partner ability word |
| exp_lp_an_able | output | 1 | Partner can negotiate |
| exp_pd_fault | output | 1 | Parallel detection fault, clear on read |
| restart_ack | output | 1 | Restart accepted pulse |

## Verification
Each result has a fixed latency from its stimulus:
- An FLP pulse becomes a resolved, up link after two edges: one to completion, one to link up.
- A single-speed parallel detect finishes DETECT_CYC edges after its first pulse, plus one.
- The restart acknowledge and link drop appear on the first edge.
- The break ends on edge BREAK_CYC.

Inputs are driven on the falling edge and outputs are sampled on the next falling edge after the counted number of rising edges. Where a result must not yet have happened, the FLP input is held high through the last break edge, so an early exit would be observed.

// File: rtl/autoneg_sequencer.sv
module autoneg_sequencer #(
  parameter int BREAK_CYC  = 60_000_000,
  parameter int DETECT_CYC = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       an_enable,
  input  logic       restart_req,
  input  logic       ctl_speed100,
  input  logic       ctl_full,
  input  logic       link_ok,
  input  logic       flp_det,
  input  logic       idle100_det,
  input  logic       nlp10_det,
  input  logic [3:0] adv_ability,
  input  logic [3:0] lp_word,
  input  logic       exp_read,
  output logic       link_up,
  output logic       txrx_en,
  output logic       speed_100,
  output logic       full_duplex,
  output logic [3:0] lp_ability,
  output logic       exp_lp_an_able,
  output logic       exp_pd_fault,
  output logic       restart_ack
);
  localparam int MAXC = (BREAK_CYC > DETECT_CYC) ? BREAK_CYC : DETECT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    ST_FORCED, ST_BREAK, ST_DETECT, ST_PARDET, ST_DONE, ST_UP
  } st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        seen100, seen10, pd_set;
  logic [3:0]  common;
  logic        s100, s10;

  assign common = adv_ability & lp_ability;
  assign s100   = seen100 | idle100_det;
  assign s10    = seen10  | nlp10_det;
  assign link_up = (st == ST_UP) | ((st == ST_FORCED) & link_ok);
  assign txrx_en = link_up;
  assign pd_set  = (st == ST_PARDET) & !flp_det & (cnt == CW'(DETECT_CYC - 1)) & s100 & s10;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_DETECT;
      cnt <= '0;
      seen100 <= 1'b0;
      seen10 <= 1'b0;
      speed_100 <= 1'b0;
      full_duplex <= 1'b0;
      lp_ability <= '0;
      exp_lp_an_able <= 1'b0;
      restart_ack <= 1'b0;
    end else begin
      restart_ack <= 1'b0;
      if (restart_req && an_enable) begin
        st <= ST_BREAK;
        cnt <= '0;
        restart_ack <= 1'b1;
      end else if (!an_enable) begin
        st <= ST_FORCED;
        speed_100 <= ctl_speed100;
        full_duplex <= ctl_full;
      end else begin
        case (st)
          ST_FORCED: st <= ST_DETECT;
          ST_BREAK: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(BREAK_CYC - 1)) st <= ST_DETECT;
          end
          ST_DETECT: begin
            if (flp_det) begin
              lp_ability <= lp_word;
              exp_lp_an_able <= 1'b1;
              st <= ST_DONE;
            end else if (idle100_det || nlp10_det) begin
              seen100 <= idle100_det;
              seen10 <= nlp10_det;
              cnt <= '0;
              st <= ST_PARDET;
            end
          end
          ST_PARDET: begin
            if (flp_det) begin
              lp_ability <= lp_word;
              exp_lp_an_able <= 1'b1;
              st <= ST_DONE;
            end else begin
              seen100 <= s100;
              seen10 <= s10;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DETECT_CYC - 1)) begin
                if (s100 && s10) begin
                  st <= ST_DETECT;
                end else begin
                  speed_100 <= s100;
                  full_duplex <= 1'b0;
                  exp_lp_an_able <= 1'b0;
                  lp_ability <= s100 ? 4'b0100 : 4'b0001;
                  st <= ST_UP;
                end
              end
            end
          end
          ST_DONE: begin
            if (common == 4'b0000) begin
              st <= ST_DETECT;
            end else begin
              speed_100 <= common[3] | common[2];
              full_duplex <= common[3] | (!common[2] & common[1]);
              st <= ST_UP;
            end
          end
          ST_UP: if (!link_ok) st <= ST_DETECT;
          default: st <= ST_DETECT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) exp_pd_fault <= 1'b0;
    else if (pd_set) exp_pd_fault <= 1'b1;
    else if (exp_read) exp_pd_fault <= 1'b0;
  end

  // R9: break counter never passes its limit
  a_r9_break_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BREAK) |-> (cnt < CW'(BREAK_CYC)));
  // R9: acknowledge coincides with entry into the break
  a_r9_ack_break: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ack |-> (st == ST_BREAK) && !txrx_en);
  // R6: a parallel-detected link is half duplex and marks a non-negotiating partner
  a_r6_pd_half: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UP && $past(st) == ST_PARDET) |-> (!full_duplex && !exp_lp_an_able));
  // R7: fault only arises out of a parallel detect window
  a_r7_fault_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_pd_fault) |-> ($past(st) == ST_PARDET) && (st == ST_DETECT));
  // R10: link drop goes directly to detection
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_UP && $past(an_enable) && !$past(restart_req) && !$past(link_ok))
    |-> (st == ST_DETECT));
  // R2: forced mode tracks control bits
  a_r2_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FORCED && $past(st) == ST_FORCED)
    |-> (speed_100 == $past(ctl_speed100)) && (full_duplex == $past(ctl_full)));
endmodule

// File: tb/autoneg_sequencer_tb.sv
`timescale 1ns/1ps
module autoneg_sequencer_tb;
  localparam int BRK = 40;
  localparam int DET = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic an_enable = 1'b1, restart_req = 1'b0, ctl_speed100 = 1'b0, ctl_full = 1'b0;
  logic link_ok = 1'b1, flp_det = 1'b0, idle100_det = 1'b0, nlp10_det = 1'b0, exp_read = 1'b0;
  logic [3:0] adv_ability = 4'hF, lp_word = 4'h0;
  logic link_up, txrx_en, speed_100, full_duplex, exp_lp_an_able, exp_pd_fault, restart_ack;
  logic [3:0] lp_ability;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  autoneg_sequencer #(.BREAK_CYC(BRK), .DETECT_CYC(DET)) u_dut (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .restart_req(restart_req),
    .ctl_speed100(ctl_speed100), .ctl_full(ctl_full), .link_ok(link_ok),
    .flp_det(flp_det), .idle100_det(idle100_det), .nlp10_det(nlp10_det),
    .adv_ability(adv_ability), .lp_word(lp_word), .exp_read(exp_read),
    .link_up(link_up), .txrx_en(txrx_en), .speed_100(speed_100), .full_duplex(full_duplex),
    .lp_ability(lp_ability), .exp_lp_an_able(exp_lp_an_able), .exp_pd_fault(exp_pd_fault),
    .restart_ack(restart_ack));

  // {adv[3:0], lp[3:0], link, speed100, full, unused}
  localparam logic [11:0] VEC [8] = '{
    {4'hF, 4'hF, 4'b1110}, {4'hF, 4'h7, 4'b1100}, {4'h3, 4'hF, 4'b1010},
    {4'h1, 4'hF, 4'b1000}, {4'hA, 4'h5, 4'b0000}, {4'h6, 4'hC, 4'b1100},
    {4'h9, 4'hB, 4'b1110}, {4'h5, 4'h3, 4'b1000}};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 link_up", 8'(link_up), 8'd0);
    chk("R1 txrx_en", 8'(txrx_en), 8'd0);
    chk("R1 expansion", {6'd0, exp_pd_fault, exp_lp_an_able}, 8'd0);
    chk("R1 lp_ability", 8'(lp_ability), 8'd0);

    // R4 / R5 resolution table
    for (int i = 0; i < 8; i++) begin
      adv_ability = VEC[i][11:8];
      lp_word = VEC[i][7:4];
      flp_det = 1'b1; tick(); flp_det = 1'b0; tick();
      chk("R4 lp_ability", 8'(lp_ability), 8'(VEC[i][7:4]));
      chk("R4 exp_lp_an_able", 8'(exp_lp_an_able), 8'd1);
      if (VEC[i][3]) begin
        chk("R4 link_up", 8'(link_up), 8'd1);
        chk("R4 mode", {6'd0, speed_100, full_duplex}, {6'd0, VEC[i][2:1]});
        link_ok = 1'b0; tick(); link_ok = 1'b1;
      end else begin
        chk("R5 link stays down", 8'(link_up), 8'd0);
      end
    end

    // R7 conflicting parallel detect, then R8 read clear
    adv_ability = 4'hF;
    idle100_det = 1'b1; tick(); idle100_det = 1'b0;
    nlp10_det = 1'b1; tick(); nlp10_det = 1'b0;
    repeat (DET + 2) tick();
    chk("R7 fault set", 8'(exp_pd_fault), 8'd1);
    chk("R7 link down", 8'(link_up), 8'd0);
    tick();
    chk("R8 fault held before read", 8'(exp_pd_fault), 8'd1);
    exp_read = 1'b1; tick(); exp_read = 1'b0;
    chk("R8 fault cleared", 8'(exp_pd_fault), 8'd0);

    // R6 parallel detect 10M
    nlp10_det = 1'b1; tick(); nlp10_det = 1'b0;
    repeat (DET + 1) tick();
    chk("R6 link_up", 8'(link_up), 8'd1);
    chk("R6 mode 10 half", {6'd0, speed_100, full_duplex}, 8'd0);
    chk("R6 exp_lp_an_able", 8'(exp_lp_an_able), 8'd0);
    chk("R6 lp_ability 10M", 8'(lp_ability), 8'h01);

    // R3 control speed/duplex ignored while AN enabled
    ctl_speed100 = 1'b1; ctl_full = 1'b1;
    repeat (3) tick();
    chk("R3 mode unchanged", {6'd0, speed_100, full_duplex}, 8'd0);

    // R6 parallel detect 100M after a drop
    link_ok = 1'b0; tick(); link_ok = 1'b1;
    idle100_det = 1'b1; tick(); idle100_det = 1'b0;
    repeat (DET + 1) tick();
    chk("R6 mode 100 half", {5'd0, link_up, speed_100, full_duplex}, 8'b110);
    chk("R6 lp_ability 100M", 8'(lp_ability), 8'h04);

    // R9 restart and break period
    restart_req = 1'b1; tick(); restart_req = 1'b0;
    chk("R9 ack", 8'(restart_ack), 8'd1);
    chk("R9 txrx off", {6'd0, link_up, txrx_en}, 8'd0);
    flp_det = 1'b1; lp_word = 4'hF;
    repeat (BRK) tick();
    flp_det = 1'b0;
    chk("R9 ack one cycle", 8'(restart_ack), 8'd0);
    chk("R9 flp ignored in break", 8'(link_up), 8'd0);
    flp_det = 1'b1; tick(); flp_det = 1'b0; tick();
    chk("R9 link after break", {5'd0, link_up, speed_100, full_duplex}, 8'b111);

    // R10 link drop goes straight to detection
    link_ok = 1'b0; tick(); link_ok = 1'b1;
    chk("R10 link dropped", 8'(link_up), 8'd0);
    flp_det = 1'b1; tick(); flp_det = 1'b0; tick();
    chk("R10 relink without break", 8'(link_up), 8'd1);

    // R2 forced mode
    ctl_speed100 = 1'b1; ctl_full = 1'b0; an_enable = 1'b0;
    tick(); tick();
    chk("R2 forced mode", {5'd0, link_up, speed_100, full_duplex}, 8'b110);
    ctl_speed100 = 1'b0; ctl_full = 1'b1; tick(); tick();
    chk("R2 forced follows ctl", {6'd0, speed_100, full_duplex}, 8'b01);
    link_ok = 1'b0; #1;
    chk("R2 forced link follows link_ok", {6'd0, link_up, txrx_en}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule